// File: doc/BRIEF.md
# Dual-Bank Register File with Pair Exchange

This block keeps the eight byte registers of an 8-bit processor core (the accumulator/flag pair, and the BC, DE and HL pairs) twice over: once in a main bank and once in a primed bank. Each register pair is 16 bits wide. The high byte holds the first-named register, so A sits in the upper byte of the AF pair. A per-pair write port loads any pair in either bank. A small exchange command set moves pair contents between the banks, or between DE and HL. Every exchange finishes in one clock edge.

A one-shot prefix qualifier can redirect the two DE/HL exchanges into the primed bank. When the qualifier is set, the main HL target becomes HL'. The core's decoder pulses the qualifier input when it sees the prefix. The block holds it until the next command executes and then drops it. All sixteen bytes are always visible on two flat read buses, one per bank, so the datapath can read any pair without a read address.

Top module: `regbank_alt`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every pair in both banks is zero after that edge, and the prefix qualifier is disarmed.
- R2: With `xchg_op` at 0 and `wr_en` high, `wr_data` is written into pair `wr_pair` (0=AF, 1=BC, 2=DE, 3=HL). It goes to the primed bank if `wr_alt` is 1 and to the main bank otherwise. Pair k appears on `rd_main`/`rd_alt` bits [16k+15:16k] after the edge, and no other pair changes.
- R3: `xchg_op`=1 swaps BC with BC', DE with DE' and HL with HL' in one edge, and leaves AF and AF' unchanged.
- R4: `xchg_op`=2 swaps AF with AF' and changes no other pair.
- R5: `xchg_op`=3 with the qualifier disarmed swaps main DE with main HL and changes no other pair.
- R6: `xchg_op`=3 with the qualifier armed swaps main DE with HL' and changes no other pair.
- R7: `xchg_op`=4 with the qualifier disarmed swaps DE' with main HL and changes no other pair.
- R8: `xchg_op`=4 with the qualifier armed swaps DE' with HL' and changes no other pair.
- R9: When `xchg_op` is 1 to 4 and `wr_en` is high in the same cycle, only the exchange takes effect and the write is discarded.
- R10: A high `alt_pfx` arms the qualifier from the next cycle on, and the qualifier stays armed over idle cycles. The first later cycle that executes a command (an exchange, or a write) uses the qualifier and then disarms it. An `alt_pfx` in the same cycle as a command arms the qualifier for the following command only.
- R11: `xchg_op` values 0, 5, 6 and 7 perform no exchange and do not consume the qualifier. A write in the same cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| xchg_op | input | 3 | Exchange command: 0 none, 1 all but AF, 2 AF, 3 DE/HL, 4 DE'/HL; 5-7 none |
| alt_pfx | input | 1 | Prefix pulse that arms the alternate-destination qualifier |
| wr_en | input | 1 | Pair write request |
| wr_alt | input | 1 | Write targets the primed bank when 1 |
| wr_pair | input | 2 | Pair to write: 0 AF, 1 BC, 2 DE, 3 HL |
| wr_data | input | 16 | Write data, upper byte is the first-named register |
| rd_main | output | 64 | Main bank, pair k on bits [16k+15:16k] |
| rd_alt | output | 64 | Primed bank, same layout |

## Verification
The whole state sits on the two read buses, so a wrong load enable or a wrong swap source shows up one edge after the command. It appears either as a pair that should not have moved, or as a value in the wrong slot. A qualifier that is armed or disarmed at the wrong time is harder to see. It shows only when the next DE/HL exchange lands in the wrong bank, which can be many cycles after the prefix pulse. For this reason the bench compares all 128 bits after every single cycle against a reference model, and it runs long random streams of prefixes, idles, writes and exchanges.

// File: rtl/regbank_pkg.sv
// Package: shared command codes and pair indices for the dual-bank register file.
// Assumes: four 16-bit pairs per bank; the pair index order is fixed because the
// write port and the read buses decode it.
package regbank_pkg;

    localparam int NPAIR    = 4;
    localparam int PAIR_IDX = 2;

    localparam int P_AF = 0;
    localparam int P_BC = 1;
    localparam int P_DE = 2;
    localparam int P_HL = 3;

    typedef enum logic [2:0] {
        XO_NONE  = 3'd0,
        XO_ALL   = 3'd1,
        XO_AF    = 3'd2,
        XO_DEHL  = 3'd3,
        XO_DEPHL = 3'd4
    } xchg_op_e;

endpackage

// File: rtl/regbank_qual.sv
// Module: one-shot alternate-destination qualifier.
// Arms on a prefix pulse, is held over idle cycles, and is consumed by the
// next command that executes. A prefix that arrives with a command arms the
// qualifier for the following command. Assumes cmd_exec is derived
// combinationally from the current inputs.
module regbank_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic pfx_in,
    input  logic cmd_exec,
    output logic armed
);

    // Qualifier state: the prefix sets it, an executed command clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (pfx_in)
            armed <= 1'b1;
        else if (cmd_exec)
            armed <= 1'b0;
    end

    assert_qual_consumed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cmd_exec && !pfx_in) |=> !armed);

    assert_qual_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_exec && !pfx_in) |=> $stable(armed));

    assert_qual_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pfx_in |=> armed);

endmodule

// File: rtl/regbank_xchg.sv
// Module: combinational next-state selector for both banks.
// Decodes the exchange command and the qualifier into per-register load enables
// and next values. It falls back to the write port only when no exchange is
// decoded, which gives exchanges priority over writes.
module regbank_xchg
    import regbank_pkg::*;
#(
    parameter int PAIR_W = 16
) (
    input  logic [2:0]                     op,
    input  logic                           qual,
    input  logic                           wr_en,
    input  logic                           wr_alt,
    input  logic [PAIR_IDX-1:0]            wr_pair,
    input  logic [PAIR_W-1:0]              wr_data,
    input  logic [NPAIR-1:0][PAIR_W-1:0]   cur_m,
    input  logic [NPAIR-1:0][PAIR_W-1:0]   cur_a,
    output logic [NPAIR-1:0][PAIR_W-1:0]   nxt_m,
    output logic [NPAIR-1:0][PAIR_W-1:0]   nxt_a,
    output logic [NPAIR-1:0]               ld_m,
    output logic [NPAIR-1:0]               ld_a,
    output logic                           cmd_exec
);

    logic xchg_valid;

    // Command legality: only codes 1 to 4 are exchanges.
    always_comb begin
        xchg_valid = (op == XO_ALL) || (op == XO_AF) ||
                     (op == XO_DEHL) || (op == XO_DEPHL);
        cmd_exec   = xchg_valid || wr_en;
    end

    // Next-value and load-enable selection per exchange kind, else the write.
    always_comb begin
        nxt_m = cur_m;
        nxt_a = cur_a;
        ld_m  = '0;
        ld_a  = '0;
        case (op)
            XO_ALL: begin
                for (int p = P_BC; p <= P_HL; p++) begin
                    nxt_m[p] = cur_a[p];
                    nxt_a[p] = cur_m[p];
                    ld_m[p]  = 1'b1;
                    ld_a[p]  = 1'b1;
                end
            end
            XO_AF: begin
                nxt_m[P_AF] = cur_a[P_AF];
                nxt_a[P_AF] = cur_m[P_AF];
                ld_m[P_AF]  = 1'b1;
                ld_a[P_AF]  = 1'b1;
            end
            XO_DEHL: begin
                ld_m[P_DE] = 1'b1;
                if (!qual) begin
                    nxt_m[P_DE] = cur_m[P_HL];
                    nxt_m[P_HL] = cur_m[P_DE];
                    ld_m[P_HL]  = 1'b1;
                end else begin
                    nxt_m[P_DE] = cur_a[P_HL];
                    nxt_a[P_HL] = cur_m[P_DE];
                    ld_a[P_HL]  = 1'b1;
                end
            end
            XO_DEPHL: begin
                ld_a[P_DE] = 1'b1;
                if (!qual) begin
                    nxt_a[P_DE] = cur_m[P_HL];
                    nxt_m[P_HL] = cur_a[P_DE];
                    ld_m[P_HL]  = 1'b1;
                end else begin
                    nxt_a[P_DE] = cur_a[P_HL];
                    nxt_a[P_HL] = cur_a[P_DE];
                    ld_a[P_HL]  = 1'b1;
                end
            end
            default: begin
                if (wr_en) begin
                    if (wr_alt) begin
                        nxt_a[wr_pair] = wr_data;
                        ld_a[wr_pair]  = 1'b1;
                    end else begin
                        nxt_m[wr_pair] = wr_data;
                        ld_m[wr_pair]  = 1'b1;
                    end
                end
            end
        endcase
    end

    // R9: a write that arrives with an exchange loads at most the pairs the exchange names
    always_comb begin
        if (xchg_valid && op == XO_AF)
            assert_af_loads_only_af_R9: assert ((ld_m[P_HL:P_BC] == '0) && (ld_a[P_HL:P_BC] == '0));
    end

endmodule

// File: rtl/regbank_store.sv
// Module: storage for both banks, one register per pair per bank.
// Each register loads its next value when its enable is high. Synchronous
// active-low reset clears everything. Assumes the enables and values come from
// a single selector in the same cycle.
module regbank_store
    import regbank_pkg::*;
#(
    parameter int PAIR_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NPAIR-1:0]               ld_m,
    input  logic [NPAIR-1:0]               ld_a,
    input  logic [NPAIR-1:0][PAIR_W-1:0]   nxt_m,
    input  logic [NPAIR-1:0][PAIR_W-1:0]   nxt_a,
    output logic [NPAIR-1:0][PAIR_W-1:0]   cur_m,
    output logic [NPAIR-1:0][PAIR_W-1:0]   cur_a
);

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        // Main-bank pair register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cur_m[p] <= '0;
            else if (ld_m[p])
                cur_m[p] <= nxt_m[p];
        end

        // Primed-bank pair register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cur_a[p] <= '0;
            else if (ld_a[p])
                cur_a[p] <= nxt_a[p];
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (cur_m == '0 && cur_a == '0));

endmodule

// File: rtl/regbank_alt.sv
// Module: dual-bank register file top.
// Ties the qualifier, the exchange selector and the storage together and
// flattens both banks onto read buses, with pair k on bits [PAIR_W*k +: PAIR_W].
// Assumes one command per cycle from the decoder; a simultaneous exchange wins.
module regbank_alt
    import regbank_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int PAIR_W = 2 * BYTE_W,
    localparam int BUS_W  = NPAIR * PAIR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           xchg_op,
    input  logic                 alt_pfx,
    input  logic                 wr_en,
    input  logic                 wr_alt,
    input  logic [PAIR_IDX-1:0]  wr_pair,
    input  logic [PAIR_W-1:0]    wr_data,
    output logic [BUS_W-1:0]     rd_main,
    output logic [BUS_W-1:0]     rd_alt
);

    logic [NPAIR-1:0][PAIR_W-1:0] cur_m, cur_a, nxt_m, nxt_a;
    logic [NPAIR-1:0]             ld_m, ld_a;
    logic                         cmd_exec;
    logic                         qual_armed;

    regbank_qual u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .pfx_in   (alt_pfx),
        .cmd_exec (cmd_exec),
        .armed    (qual_armed)
    );

    regbank_xchg #(.PAIR_W(PAIR_W)) u_xchg (
        .op       (xchg_op),
        .qual     (qual_armed),
        .wr_en    (wr_en),
        .wr_alt   (wr_alt),
        .wr_pair  (wr_pair),
        .wr_data  (wr_data),
        .cur_m    (cur_m),
        .cur_a    (cur_a),
        .nxt_m    (nxt_m),
        .nxt_a    (nxt_a),
        .ld_m     (ld_m),
        .ld_a     (ld_a),
        .cmd_exec (cmd_exec)
    );

    regbank_store #(.PAIR_W(PAIR_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_m  (ld_m),
        .ld_a  (ld_a),
        .nxt_m (nxt_m),
        .nxt_a (nxt_a),
        .cur_m (cur_m),
        .cur_a (cur_a)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_rd
        assign rd_main[p*PAIR_W +: PAIR_W] = cur_m[p];
        assign rd_alt [p*PAIR_W +: PAIR_W] = cur_a[p];
    end

    assert_full_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_op == XO_ALL) |=>
            (cur_m[P_HL:P_BC] == $past(cur_a[P_HL:P_BC])) &&
            (cur_a[P_HL:P_BC] == $past(cur_m[P_HL:P_BC])) &&
            $stable(cur_m[P_AF]) && $stable(cur_a[P_AF]));

    // R4 and R9: an AF exchange leaves every other pair alone, even with a write pending
    assert_af_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_op == XO_AF) |=>
            (cur_m[P_AF] == $past(cur_a[P_AF])) &&
            $stable(cur_m[P_HL:P_BC]) && $stable(cur_a[P_HL:P_BC]));

    assert_dehl_main_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_op == XO_DEHL && !qual_armed) |=>
            (cur_m[P_DE] == $past(cur_m[P_HL])) && (cur_m[P_HL] == $past(cur_m[P_DE])) &&
            $stable(cur_a));

    assert_dehl_alt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_op == XO_DEHL && qual_armed) |=>
            (cur_m[P_DE] == $past(cur_a[P_HL])) && (cur_a[P_HL] == $past(cur_m[P_DE])) &&
            $stable(cur_m[P_HL]) && $stable(cur_a[P_DE]));

    assert_dephl_alt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_op == XO_DEPHL && qual_armed) |=>
            (cur_a[P_DE] == $past(cur_a[P_HL])) && (cur_a[P_HL] == $past(cur_a[P_DE])) &&
            $stable(cur_m));

    assert_noop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_op > 3'd4 && !wr_en) |=> ($stable(cur_m) && $stable(cur_a)));

endmodule

// File: tb/regbank_alt_tb_top.sv
`timescale 1ns/1ps
// Bench: a scoreboard for the dual-bank register file.
// The driver task applies one cycle of stimulus, steps a reference model and
// queues the expected contents of both banks. The monitor pops one entry and
// compares it after each rising edge.
module regbank_alt_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  xchg_op = '0;
    logic        alt_pfx = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_alt = 1'b0;
    logic [1:0]  wr_pair = '0;
    logic [15:0] wr_data = '0;
    logic [63:0] rd_main, rd_alt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0]  mm [4];
    logic [15:0]  ma [4];
    bit           pend;
    logic [127:0] q_exp [$];
    string        q_tag [$];

    always #2.5 clk = ~clk;

    regbank_alt dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .xchg_op (xchg_op),
        .alt_pfx (alt_pfx),
        .wr_en   (wr_en),
        .wr_alt  (wr_alt),
        .wr_pair (wr_pair),
        .wr_data (wr_data),
        .rd_main (rd_main),
        .rd_alt  (rd_alt)
    );

    function automatic logic [127:0] snap();
        return {ma[3], ma[2], ma[1], ma[0], mm[3], mm[2], mm[1], mm[0]};
    endfunction

    // Reference model step taken from the requirements.
    function automatic void model_step(logic [2:0] op, bit pfx, bit we, bit walt,
                                       logic [1:0] wp, logic [15:0] wd);
        logic [15:0] t;
        bit valid = (op >= 3'd1 && op <= 3'd4);
        case (op)
            3'd1: for (int p = 1; p < 4; p++) begin t = mm[p]; mm[p] = ma[p]; ma[p] = t; end
            3'd2: begin t = mm[0]; mm[0] = ma[0]; ma[0] = t; end
            3'd3: if (!pend) begin t = mm[2]; mm[2] = mm[3]; mm[3] = t; end
                  else begin t = mm[2]; mm[2] = ma[3]; ma[3] = t; end
            3'd4: if (!pend) begin t = ma[2]; ma[2] = mm[3]; mm[3] = t; end
                  else begin t = ma[2]; ma[2] = ma[3]; ma[3] = t; end
            default: if (we) begin if (walt) ma[wp] = wd; else mm[wp] = wd; end
        endcase
        if (pfx) pend = 1'b1;
        else if (valid || we) pend = 1'b0;
    endfunction

    task automatic drive(logic [2:0] op, bit pfx, bit we, bit walt,
                         logic [1:0] wp, logic [15:0] wd, string tag);
        @(negedge clk);
        xchg_op = op; alt_pfx = pfx; wr_en = we; wr_alt = walt;
        wr_pair = wp; wr_data = wd;
        model_step(op, pfx, we, walt, wp, wd);
        q_exp.push_back(snap());
        q_tag.push_back(tag);
    endtask

    task automatic do_reset(string tag);
        @(negedge clk);
        rst_n = 1'b0;
        xchg_op = '0; alt_pfx = 1'b0; wr_en = 1'b0;
        for (int p = 0; p < 4; p++) begin mm[p] = '0; ma[p] = '0; end
        pend = 1'b0;
        q_exp.push_back(snap());
        q_tag.push_back(tag);
        @(negedge clk);
        rst_n = 1'b1;
        q_exp.push_back(snap());
        q_tag.push_back(tag);
    endtask

    task automatic wr(bit walt, logic [1:0] wp, logic [15:0] wd);
        drive(3'd0, 1'b0, 1'b1, walt, wp, wd, "R2");
    endtask

    task automatic fill();
        for (int p = 0; p < 4; p++) begin
            wr(1'b0, p[1:0], 16'h1100 * (p + 1) + 16'h0011);
            wr(1'b1, p[1:0], 16'hA000 + 16'h0101 * (p + 1));
        end
    endtask

    // Monitor: one comparison per cycle while expectations are queued.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() > 0) begin
                logic [127:0] e;
                string tg;
                e  = q_exp.pop_front();
                tg = q_tag.pop_front();
                checks++;
                if ({rd_alt, rd_main} !== e) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", tg, {rd_alt, rd_main}, e);
                end
            end
        end
    end

    // Stimulus: directed corner cases, then a random stream.
    initial begin
        for (int p = 0; p < 4; p++) begin mm[p] = '0; ma[p] = '0; end
        pend = 1'b0;
        // R1: reset state, after dirtying inputs
        wr_en = 1'b1; wr_data = 16'hFFFF;
        do_reset("R1");
        fill();
        drive(3'd1, 0, 0, 0, 0, 0, "R3");
        drive(3'd2, 0, 0, 0, 0, 0, "R4");
        drive(3'd3, 0, 0, 0, 0, 0, "R5");
        drive(3'd0, 1, 0, 0, 0, 0, "R10");
        drive(3'd0, 0, 0, 0, 0, 0, "R10");
        drive(3'd3, 0, 0, 0, 0, 0, "R6");
        drive(3'd4, 0, 0, 0, 0, 0, "R7");
        drive(3'd0, 1, 0, 0, 0, 0, "R10");
        drive(3'd4, 0, 0, 0, 0, 0, "R8");
        drive(3'd3, 0, 0, 0, 0, 0, "R10");
        drive(3'd2, 0, 1, 0, 2'd1, 16'hDEAD, "R9");
        drive(3'd1, 0, 1, 1, 2'd0, 16'hBEEF, "R9");
        drive(3'd0, 1, 0, 0, 0, 0, "R10");
        drive(3'd6, 0, 1, 1, 2'd3, 16'h5A5A, "R11");
        drive(3'd7, 0, 0, 0, 0, 0, "R11");
        drive(3'd3, 0, 0, 0, 0, 0, "R11");
        drive(3'd0, 1, 0, 0, 0, 0, "R10");
        wr(1'b0, 2'd2, 16'h0F0F);
        drive(3'd3, 0, 0, 0, 0, 0, "R10");
        drive(3'd3, 1, 0, 0, 0, 0, "R10");
        drive(3'd4, 0, 0, 0, 0, 0, "R10");
        drive(3'd0, 1, 0, 0, 0, 0, "R1");
        do_reset("R1");
        drive(3'd3, 0, 0, 0, 0, 0, "R1");
        fill();
        for (int i = 0; i < 600; i++) begin
            logic [2:0] op = 3'($urandom_range(0, 7));
            drive(op, ($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 1),
                  1'($urandom), 2'($urandom), 16'($urandom), "R3-R11 random");
            if (i == 300) do_reset("R1");
        end
        drive(3'd0, 0, 0, 0, 0, 0, "R2");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule